// File: doc/BRIEF.md
# Serial Control Word Transmitter

This block is a bus master for a three-wire control port made of a serial clock, a data line and a load strobe. A host hands it an 11-bit control word. The block lowers the load strobe and shifts the word out least significant bit first, one bit per serial clock pulse. It raises the strobe while the last pulse is still high, then drops the clock and goes quiet until the next word arrives. The receiving side updates its parallel outputs when the strobe rises, so that rising edge is where the word takes effect.

All serial timing is built from one unit, the phase. A phase lasts `half_div` system clock cycles, and that value is captured when the word is accepted. The host must choose `half_div` so that one phase lasts at least 1 µs. With that setting the serial clock runs at no more than 500 kHz and every setup, hold and pulse-width window at the port is met.

The word enters through a valid/ready handshake. `in_ready` is high exactly when no frame is in progress. The source must hold `in_word` and `half_div` steady while `in_valid` is high and `in_ready` is low. A transfer takes place on the rising edge where both are high. `done` pulses for one cycle when a frame ends.

Top module: `scw_tx`

## Requirements
- R1: After reset, `ser_clk` is 0, `ser_load` is 1, `ser_data` is 0, `busy` is 0 and `done` is 0.
- R2: `in_ready` equals the inverse of `busy`. A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1, and `busy` is 1 from the next cycle. A request held high during a frame has no effect on that frame and is taken only once the frame has ended.
- R3: Take H as the phase length in cycles and A as the edge that accepts a word. `ser_load` falls at edge A and stays 0 until the last bit has been clocked in. `ser_data` stays unchanged for the first phase, from A to A+H.
- R4: Exactly 11 pulses appear on `ser_clk` per frame. Pulse k (k = 1..11) rises at A+2kH. Pulses 1 to 10 stay high for H cycles, the low phases between pulses last H cycles, and pulse 11 stays high for 2H cycles.
- R5: Bit k of the frame is `in_word[k-1]`, so D1 is bit 0 and goes out first. It appears on `ser_data` at A+(2k-1)H, and every change of `ser_data` inside a frame happens while `ser_clk` is 0.
- R6: `ser_load` rises at A+23H, H cycles after the 11th rising edge of `ser_clk`. `ser_clk` falls at A+24H, another H cycles later.
- R7: At A+24H, `busy` falls and `done` is 1 for exactly one cycle, in the same cycle as the final fall of `ser_clk`.
- R8: `half_div` is sampled only at acceptance, and a value of 0 acts as 1. Changing it during a frame has no effect on that frame, and every frame keeps `busy` high for exactly 24H cycles.
- R9: Between frames, `ser_clk` rests at 0, `ser_load` rests at 1, and `ser_data` keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A control word is offered |
| in_ready | output | 1 | The block can take a word (idle) |
| in_word | input | 11 | Control word; bit 0 is sent first |
| half_div | input | 16 | Serial phase length in system cycles (0 acts as 1) |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data |
| ser_load | output | 1 | Load strobe, low during the shift |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Two events can fall in the same cycle. One is the end of a frame: `done` pulses, the clock falls and `busy` drops. The other is a new request that the source has held high throughout that frame. The bench provokes this by offering a second word right after the first is taken, and it changes `half_div` while the first frame runs. A behavioural timeline model, which counts phases from the acceptance edge, is compared on every cycle against all outputs. It checks that the held word is taken only on the edge after `done` and that the first frame keeps its original phase length. A separate per-frame check of the busy length covers the same point.

// File: rtl/scw_pkg.sv
package scw_pkg;
  localparam int unsigned WORD_BITS = 11;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_LATCH = 3'd4
  } scw_phase_e;
endpackage

// File: rtl/scw_tick.sv
module scw_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] span_m1,
  input  logic             active,
  output logic             expire
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= span_m1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = active && (cnt_q == '0);
endmodule

// File: rtl/scw_shift.sv
module scw_shift #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              advance,
  output logic              sdata,
  output logic              all_sent
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sh_q  <= word;
      cnt_q <= '0;
    end else if (advance) begin
      sdata <= sh_q[0];
      sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign all_sent = (cnt_q == CNT_W'(WORD_W));

  // R4: never more bits than the word holds
  a_r4_bit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/scw_seq.sv
module scw_seq
  import scw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic expire,
  input  logic all_sent,
  output logic advance,
  output logic sclk,
  output logic sload,
  output logic busy,
  output logic done
);
  scw_phase_e ph_q;

  assign busy    = (ph_q != PH_IDLE);
  assign advance = expire && ((ph_q == PH_LEAD) || ((ph_q == PH_HIGH) && !all_sent));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      sclk  <= 1'b0;
      sload <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          ph_q  <= PH_LEAD;
          sload <= 1'b0;
        end
        PH_LEAD: if (expire) ph_q <= PH_LOW;
        PH_LOW: if (expire) begin
          ph_q <= PH_HIGH;
          sclk <= 1'b1;
        end
        PH_HIGH: if (expire) begin
          if (all_sent) begin
            ph_q  <= PH_LATCH;
            sload <= 1'b1;
          end else begin
            ph_q <= PH_LOW;
            sclk <= 1'b0;
          end
        end
        PH_LATCH: if (expire) begin
          ph_q <= PH_IDLE;
          sclk <= 1'b0;
          done <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R3: every clock rise happens with the strobe low
  a_r3_rise_under_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !sload);
  // R6: the strobe rises while the clock is still high
  a_r6_load_rise_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) |-> sclk);
  // R7: done lasts one cycle and comes with the final clock fall
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(sclk) && !busy);
endmodule

// File: rtl/scw_tx.sv
module scw_tx
  import scw_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [DIV_W-1:0]  half_div,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_load,
  output logic              busy,
  output logic              done
);
  logic             accept, expire, advance, all_sent;
  logic [DIV_W-1:0] div_m1, span_q, span_now;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign div_m1   = (half_div == '0) ? '0 : half_div - 1'b1;
  assign span_now = accept ? div_m1 : span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      span_q <= '0;
    else if (accept) span_q <= div_m1;
  end

  scw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(accept || expire),
    .span_m1(span_now), .active(busy), .expire(expire)
  );

  scw_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(in_word),
    .advance(advance), .sdata(ser_data), .all_sent(all_sent)
  );

  scw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .expire(expire),
    .all_sent(all_sent), .advance(advance), .sclk(ser_clk),
    .sload(ser_load), .busy(busy), .done(done)
  );

  // R5: data moves only while the clock is low and the strobe is low
  a_r5_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> !ser_clk && !ser_load);
  // R9: idle keeps clock low and strobe high
  a_r9_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk && ser_load);
endmodule

// File: tb/scw_tx_tb.sv
module scw_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [10:0] in_word = '0;
  logic [15:0] half_div = 16'd1;
  logic        in_ready, ser_clk, ser_data, ser_load, busy, done;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  scw_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .half_div(half_div), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_load(ser_load), .busy(busy), .done(done)
  );

  // behavioural timeline model
  int   n = 0, hh = 1, tt = 24, m = 0, k = 0, blen = 0;
  bit   act = 0, fin = 0, took = 0;
  logic [10:0] mw = '0;
  logic mlast = 1'b0;

  always @(posedge clk) begin
    fin = 0;
    took = 0;
    if (!rst_n) begin
      act = 0;
      mlast = 1'b0;
    end else if (act) begin
      n++;
      if (n == tt) begin
        act = 0;
        fin = 1;
        mlast = mw[10];
      end
    end else if (in_valid) begin
      act = 1;
      n = 0;
      mw = in_word;
      hh = (half_div == 0) ? 1 : int'(half_div);
      tt = 24 * hh;
      took = 1;
    end
  end

  task automatic chk(input logic act_v, input logic exp_v, input string tag, input string sig);
    checks++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, sig, $time, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (act) begin
        m = n / hh;
        chk(ser_clk, ((m >= 2) && (m % 2 == 0)) || (m == 23), "R4", "ser_clk");
        chk(ser_load, m >= 23, (m >= 23) ? "R6" : "R3", "ser_load");
        if (m == 0) chk(ser_data, mlast, "R3", "ser_data");
        else begin
          k = (m + 1) / 2;
          if (k > 11) k = 11;
          chk(ser_data, mw[k-1], "R5", "ser_data");
        end
        chk(busy, 1'b1, "R2", "busy");
        chk(done, 1'b0, "R7", "done");
      end else begin
        chk(ser_clk, 1'b0, "R9", "ser_clk");
        chk(ser_load, 1'b1, "R9", "ser_load");
        chk(ser_data, mlast, "R9", "ser_data");
        chk(busy, 1'b0, "R2", "busy");
        chk(done, fin, "R7", "done");
      end
      chk(in_ready, !busy, "R2", "in_ready");
      if (busy) blen++;
      if (done) begin
        checks++;
        if (blen != tt) begin
          bad++;
          $display("FAIL R8 frame length: actual=%0d expected=%0d", blen, tt);
        end
        blen = 0;
      end
    end
  end

  task automatic send(input logic [10:0] w, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    half_div = d;
    do @(negedge clk); while (!took);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ser_clk, 1'b0, "R1", "ser_clk");
    chk(ser_load, 1'b1, "R1", "ser_load");
    chk(ser_data, 1'b0, "R1", "ser_data");
    chk(busy, 1'b0, "R1", "busy");
    chk(done, 1'b0, "R1", "done");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(11'b101_1001_0110, 16'd1);  // R4 R5 shortest phases
    wait_idle();
    send(11'h7FF, 16'd0);            // R8 zero acts as one
    wait_idle();
    send(11'h000, 16'd3);            // R5 all bits flip low
    wait_idle();
    send(11'h4A3, 16'd2);            // R2 R8 second request held while busy
    send(11'h35C, 16'd5);
    wait_idle();
    send(11'h555, 16'd200);          // 1 us phases at 200 MHz
    wait_idle();
    finish_run();
  end
endmodule